// File: doc/BRIEF.md
# Per-Lane Skew Matcher

The block sits on one receive data lane of a multi-lane link that carries an extra reference lane. Once the reference lane has been framed upstream, every frame on it carries a few copies of words taken from each data lane. The matcher takes its own lane's 16-bit word stream and passes it through a delay that can be set to any number of bits. It compares the delayed words with the copies in the reference frame that belong to this lane, and searches for the bit delay at which the two agree.

When the search finds a match, the delay is held. The delay is only dropped, and the search resumed, after a run of consecutive frames that each contain a disagreement. Every lane in the link runs its own instance. The delay each one settles on makes its data line up with the lane that arrived latest, so the delayed outputs of all lanes come out mutually aligned.

The framer upstream tells the block three things: whether the reference lane is in frame, which cycles carry this lane's copied words, and when a frame ends. The block returns the delayed lane data, the delay it has chosen, and a one-cycle pulse for every copied word that disagrees.

Top module: `skew_lane_matcher`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `dly_out` is 0, `lane_out` is 0 and `mism` is 0. The block starts in the searching state.
- R2: While `in_frame` is low, `dly_out` does not change and `mism` stays low. `frame_end` and `samp_vld` have no effect. Any held match is given up.
- R3: While searching and `in_frame` is high, `dly_out` rises by one at the clock edge that samples `frame_end`, unless the frame just ended was clean.
- R4: A frame is clean only when all 4 (`SAMPLES`) words flagged by `samp_vld` in that frame equal the delayed lane word and none differs. A frame with 3 equal words and 1 differing word is not clean, so the delay still steps.
- R5: A clean frame ends the search. `dly_out` is then held for as long as frames keep arriving without a differing word.
- R6: `mism` is high for exactly the one cycle after each in-frame `samp_vld` cycle in which the delayed lane word differs from `ref_data` in at least one bit. It is not latched.
- R7: The lane is treated as a bit stream, sent most significant bit first. For each clock edge, take the last bit of the word captured at that edge. `lane_out` after the next edge holds the 16 bits that end `dly_out` bits before that last bit. `ref_data` is compared against this same word.
- R8: While holding a delay, only `MISS_LIMIT` consecutive frames (default 4, allowed 1 to 64) that each contain a differing word return the block to searching. The return to searching keeps `dly_out` unchanged. A frame with no differing word clears the run.
- R9: The delay steps with wrap-around: after 127 (2^`DLY_W`-1) the next step gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_frame | input | 1 | Reference lane is framed |
| samp_vld | input | 1 | `ref_data` holds a copied word of this lane this cycle |
| frame_end | input | 1 | Last cycle of a reference frame |
| lane_in | input | LANE_W | Raw word of this lane |
| ref_data | input | LANE_W | Reference lane word |
| lane_out | output | LANE_W | Delayed lane word |
| dly_out | output | DLY_W | Delay currently inserted, in bits |
| mism | output | 1 | One-cycle pulse per differing copied word |

## Verification
The bench places the true skew at 37 bits and lets the search climb to it from 0. It then relocks after a forced loss of lock, which drives the delay through the 127-to-0 wrap. A design that did not wrap would get stuck at the top, and one that wrapped early would show the wrong delay at the check point.

Several corner cases each expose a specific fault:
- One frame with a single flipped bit must give exactly one pulse. A latching design shows a longer pulse.
- Three bad frames followed by a good one must leave the delay alone. A counter that never clears would unlock early.
- Four bad frames in a row must unlock without stepping the delay.
- A search frame where three copies match and one does not must still step the delay. A design that accepts a partial match would lock at the wrong delay.

// File: rtl/skm_pkg.sv
package skm_pkg;
  typedef enum logic {
    ST_SEEK = 1'b0,
    ST_HOLD = 1'b1
  } skm_state_e;
endpackage

// File: rtl/skm_delay_line.sv
// Bit-granular delay: a shift window of whole words, read at a bit offset.
module skm_delay_line #(
  parameter int W     = 16,
  parameter int DLY_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     lane_in,
  input  logic [DLY_W-1:0] dly,
  output logic [W-1:0]     dly_word
);
  localparam int SPAN   = (1 << DLY_W) - 1 + W;
  localparam int WORDS  = (SPAN + W - 1) / W;
  localparam int HIST_W = WORDS * W;

  // newest word in the low bits; older bits sit higher
  logic [HIST_W-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[HIST_W-W-1:0], lane_in};
  end

  assign dly_word = W'(hist >> dly);
endmodule

// File: rtl/skm_compare.sv
// Per-frame tally of copied-word comparisons, plus registered data/pulse.
module skm_compare #(
  parameter int W       = 16,
  parameter int SAMPLES = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_frame,
  input  logic         samp_vld,
  input  logic         frame_end,
  input  logic [W-1:0] ref_data,
  input  logic [W-1:0] dly_word,
  output logic [W-1:0] lane_out,
  output logic         mism,
  output logic         frm_done,
  output logic         frm_clean,
  output logic         frm_bad
);
  localparam int CW = $clog2(SAMPLES + 1);

  logic [CW-1:0] eq_cnt, eq_now;
  logic          bad_acc, hit, neq, bad_now;

  assign hit     = in_frame & samp_vld;
  assign neq     = (dly_word != ref_data);
  assign bad_now = bad_acc | (hit & neq);
  assign eq_now  = (eq_cnt == CW'(SAMPLES)) ? eq_cnt
                 : eq_cnt + CW'(hit & ~neq);

  assign frm_done  = in_frame & frame_end;
  assign frm_bad   = bad_now;
  assign frm_clean = (eq_now == CW'(SAMPLES)) & ~bad_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_out <= '0;
      mism     <= 1'b0;
      eq_cnt   <= '0;
      bad_acc  <= 1'b0;
    end else begin
      lane_out <= dly_word;
      mism     <= hit & neq;
      if (frame_end || !in_frame) begin
        eq_cnt  <= '0;
        bad_acc <= 1'b0;
      end else begin
        eq_cnt  <= eq_now;
        bad_acc <= bad_now;
      end
    end
  end
endmodule

// File: rtl/skm_ctrl.sv
// Search / hold state machine with consecutive-bad-frame hysteresis.
module skm_ctrl
  import skm_pkg::*;
#(
  parameter int DLY_W      = 7,
  parameter int MISS_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_frame,
  input  logic             frm_done,
  input  logic             frm_clean,
  input  logic             frm_bad,
  output logic [DLY_W-1:0] dly
);
  localparam int MW = $clog2(MISS_LIMIT + 1);

  skm_state_e    state;
  logic [MW-1:0] miss;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_SEEK;
      dly   <= '0;
      miss  <= '0;
    end else if (!in_frame) begin
      state <= ST_SEEK;
      miss  <= '0;
    end else if (frm_done) begin
      case (state)
        ST_SEEK: begin
          if (frm_clean) begin
            state <= ST_HOLD;
            miss  <= '0;
          end else begin
            dly <= dly + 1'b1;   // wraps at the top naturally
          end
        end
        default: begin
          if (!frm_bad) begin
            miss <= '0;
          end else if (miss == MW'(MISS_LIMIT - 1)) begin
            state <= ST_SEEK;
            miss  <= '0;
          end else begin
            miss <= miss + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/skew_lane_matcher.sv
module skew_lane_matcher #(
  parameter int LANE_W     = 16,
  parameter int DLY_W      = 7,
  parameter int SAMPLES    = 4,
  parameter int MISS_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_frame,
  input  logic              samp_vld,
  input  logic              frame_end,
  input  logic [LANE_W-1:0] lane_in,
  input  logic [LANE_W-1:0] ref_data,
  output logic [LANE_W-1:0] lane_out,
  output logic [DLY_W-1:0]  dly_out,
  output logic              mism
);
  logic [LANE_W-1:0] dly_word;
  logic              frm_done, frm_clean, frm_bad;

  skm_delay_line #(.W(LANE_W), .DLY_W(DLY_W)) u_dline (
    .clk(clk), .rst(rst), .lane_in(lane_in), .dly(dly_out), .dly_word(dly_word)
  );

  skm_compare #(.W(LANE_W), .SAMPLES(SAMPLES)) u_cmp (
    .clk(clk), .rst(rst), .in_frame(in_frame), .samp_vld(samp_vld),
    .frame_end(frame_end), .ref_data(ref_data), .dly_word(dly_word),
    .lane_out(lane_out), .mism(mism), .frm_done(frm_done),
    .frm_clean(frm_clean), .frm_bad(frm_bad)
  );

  skm_ctrl #(.DLY_W(DLY_W), .MISS_LIMIT(MISS_LIMIT)) u_ctrl (
    .clk(clk), .rst(rst), .in_frame(in_frame), .frm_done(frm_done),
    .frm_clean(frm_clean), .frm_bad(frm_bad), .dly(dly_out)
  );
endmodule

// File: rtl/skew_lane_matcher_chk.sv
module skew_lane_matcher_chk #(
  parameter int LANE_W = 16,
  parameter int DLY_W  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              in_frame,
  input logic              samp_vld,
  input logic              frame_end,
  input logic [LANE_W-1:0] ref_data,
  input logic [LANE_W-1:0] lane_out,
  input logic [DLY_W-1:0]  dly_out,
  input logic              mism
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_frame |=> $stable(dly_out));

  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(dly_out) |-> ($past(frame_end && in_frame) &&
                           dly_out == DLY_W'($past(dly_out) + 1'b1)));

  p_pulse_src_r6: assert property (@(posedge clk) disable iff (rst)
    mism |-> $past(in_frame && samp_vld));

  p_pulse_diff_r6: assert property (@(posedge clk) disable iff (rst)
    mism |-> (lane_out != $past(ref_data)));

  p_quiet_same_r7: assert property (@(posedge clk) disable iff (rst)
    (!mism && $past(in_frame && samp_vld)) |-> (lane_out == $past(ref_data)));
endmodule

bind skew_lane_matcher skew_lane_matcher_chk #(.LANE_W(LANE_W), .DLY_W(DLY_W)) chk_i (
  .clk(clk), .rst(rst), .in_frame(in_frame), .samp_vld(samp_vld),
  .frame_end(frame_end), .ref_data(ref_data), .lane_out(lane_out),
  .dly_out(dly_out), .mism(mism)
);

// File: tb/skew_lane_matcher_tb_top.sv
module skew_lane_matcher_tb_top;
  localparam int W = 16;
  localparam int D = 37;        // true skew in bits
  localparam int FLEN = 10;     // cycles per frame; samples at slots 2..5

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_frame = 1'b0, samp_vld = 1'b0, frame_end = 1'b0;
  logic [W-1:0] lane_in = '0, ref_data = '0;
  logic [W-1:0] lane_out;
  logic [6:0]   dly_out;
  logic         mism;

  int n_tests = 0, n_fail = 0, mism_seen = 0, n = 0;
  bit chk_on = 1'b0;
  logic [W-1:0] words [0:8191];
  logic [W-1:0] exp_q [$];

  always #2 clk = ~clk;   // 250 MHz

  skew_lane_matcher dut_i (
    .clk(clk), .rst(rst), .in_frame(in_frame), .samp_vld(samp_vld),
    .frame_end(frame_end), .lane_in(lane_in), .ref_data(ref_data),
    .lane_out(lane_out), .dly_out(dly_out), .mism(mism)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stream word ending d bits before the end of word m (MSB first)
  function automatic logic [W-1:0] dlyw(input int m, input int d);
    logic [10*W-1:0] cat;
    cat = '0;
    for (int k = 0; k < 10; k++)
      cat[k*W +: W] = (m - k >= 0) ? words[m-k] : '0;
    return cat[d +: W];
  endfunction

  // scoreboard monitor: compares lane_out (R7) and counts pulses
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      e = exp_q.pop_front();
      check(lane_out == e, "R7 lane_out", int'(lane_out), int'(e));
    end
    if (mism) mism_seen++;
  end

  // one frame; badmask flips bit 0 of chosen copied words
  task automatic run_frame(input bit inf, input int dt, input bit [3:0] badmask);
    for (int p = 0; p < FLEN; p++) begin
      logic [W-1:0] w;
      w = W'($urandom);
      words[n] = w;
      lane_in   = w;
      in_frame  = inf;
      samp_vld  = (p >= 2 && p <= 5);
      frame_end = (p == FLEN - 1);
      if (samp_vld) ref_data = dlyw(n - 1, dt) ^ {15'd0, badmask[p-2]};
      else          ref_data = W'($urandom);
      if (chk_on) exp_q.push_back(dlyw(n - 1, dt));
      n++;
      @(posedge clk); #2;
    end
  endtask

  initial begin
    #(4 * 20000);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(dly_out == 0, "R1 dly reset", int'(dly_out), 0);
    check(lane_out == 0, "R1 lane_out reset", int'(lane_out), 0);
    check(mism == 0, "R1 mism reset", int'(mism), 0);
    rst = 1'b0;

    // R2: out of frame, mismatching data and frame ends are ignored
    mism_seen = 0;
    repeat (3) run_frame(1'b0, D, 4'hF);
    check(dly_out == 0, "R2 dly held out of frame", int'(dly_out), 0);
    check(mism_seen == 0, "R2 no pulse out of frame", mism_seen, 0);

    // R3: search steps one per non-clean frame
    run_frame(1'b1, D, 4'h0);
    check(dly_out == 1, "R3 first step", int'(dly_out), 1);
    repeat (D - 1) run_frame(1'b1, D, 4'h0);
    check(dly_out == D, "R3 reached skew", int'(dly_out), D);

    // R5: clean frame locks; R7 scoreboard while locked; R6 no pulses
    chk_on = 1'b1;
    mism_seen = 0;
    repeat (5) run_frame(1'b1, D, 4'h0);
    chk_on = 1'b0;
    check(dly_out == D, "R5 held after lock", int'(dly_out), D);
    check(mism_seen == 0, "R6 no pulse when clean", mism_seen, 0);

    // R6: single bit error gives exactly one pulse
    mism_seen = 0;
    run_frame(1'b1, D, 4'b0010);
    check(mism_seen == 1, "R6 single pulse", mism_seen, 1);
    run_frame(1'b1, D, 4'h0);

    // R8: three bad then one good keeps lock
    repeat (3) run_frame(1'b1, D, 4'b0001);
    run_frame(1'b1, D, 4'h0);
    check(dly_out == D, "R8 short run kept", int'(dly_out), D);
    repeat (4) run_frame(1'b1, D, 4'b0001);
    check(dly_out == D, "R8 unlock keeps delay", int'(dly_out), D);
    run_frame(1'b1, D, 4'b0001);
    check(dly_out == D + 1, "R8 search resumed", int'(dly_out), D + 1);

    // R9: climb to the top and wrap
    repeat (127 - (D + 1)) run_frame(1'b1, D, 4'h0);
    check(dly_out == 127, "R9 top value", int'(dly_out), 127);
    run_frame(1'b1, D, 4'h0);
    check(dly_out == 0, "R9 wrap to zero", int'(dly_out), 0);

    // R4: three of four copies equal at delay 0 is still a step
    run_frame(1'b1, 0, 4'b1000);
    check(dly_out == 1, "R4 partial match steps", int'(dly_out), 1);
    repeat (D - 1) run_frame(1'b1, D, 4'h0);
    check(dly_out == D, "R3 second search", int'(dly_out), D);
    chk_on = 1'b1;
    repeat (4) run_frame(1'b1, D, 4'h0);
    chk_on = 1'b0;
    check(dly_out == D, "R5 relocked", int'(dly_out), D);

    repeat (3) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule